// File: doc/BRIEF.md
# SPI Flash Status Register Writer

This block is the slave-side control for the status register of a serial flash device. It watches chip select, serial clock and serial data from the SPI pins and brings them into a fast internal clock domain. It decodes three one-byte commands from that stream. Write-enable (0x06) arms a latch. Write-status (0x01), followed by one data byte, updates the protection fields. Read-status (0x05) shifts the register back out on the serial output.

An accepted status write starts a self-timed busy cycle that lasts `TW_CYCLES` internal clocks. During that cycle the busy bit reads 1 and only read-status frames are honoured. When the cycle ends the busy bit and the enable latch both clear. A register-lock bit, together with an active-low write-protect pin, can freeze the register entirely. The register value is also presented in parallel for the protected-area logic next to this block.

Top module: `sfl_status_writer`

## Requirements
- R1: After reset the status byte is 0x00 and the serial output is 0.
- R2: A frame of exactly 8 bits carrying 0x06 sets the enable latch at bit 1. A frame carrying 0x06 with any other bit count leaves the latch unchanged.
- R3: A write-status frame is executed only while the enable latch is 1. Without the latch the register is left unchanged.
- R4: A write-status frame is executed only if chip select rises after exactly 16 bits (0x01 then the data byte, each MSB first). A frame of 15 or 17 bits changes nothing.
- R5: Only bit 7 (register lock) and bits 4:2 (protect level 2:0) take the written data. Bits 6 and 5 always read 0, and bits 1 and 0 are never loaded from the data.
- R6: An executed status write raises bit 0 (busy) for exactly `TW_CYCLES` internal clock cycles.
- R7: When the busy cycle ends, the enable latch (bit 1) is 0.
- R8: When bit 7 is 1 and the write-protect pin is low, a write-status frame is not executed and the enable latch keeps its value. With any other combination the write proceeds.
- R9: After a 0x05 command byte, the status byte appears on the serial output MSB first. Each bit changes after a falling clock edge and is valid at the next rising edge. This also works during the busy cycle.
- R10: While busy is 1, write-enable and write-status frames have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running internal clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, data sampled on its rising edge |
| spi_mosi | input | 1 | Serial data into the block |
| wr_prot_n | input | 1 | Write-protect pin, active low |
| spi_miso | output | 1 | Serial data out, 0 when no read is in progress |
| status_o | output | 8 | Current status byte |

## Verification
A wrong busy timer shows up on `status_o[0]` as a busy pulse that is not `TW_CYCLES` long, visible in the cycle the pulse ends. A stuck or wrongly gated enable latch or lock decision shows up in the first read-status frame after the offending write, because the protection fields either change when they must not or stay fixed when they should take the data. A bit-counter or edge-detect fault corrupts either the frame-length check or the serial output, and that corruption is visible within one frame.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_WRSR = 8'h01;
   localparam logic [7:0] OP_RDSR = 8'h05;

   // frame lengths that make a command valid at chip-select release
   localparam int unsigned LEN_CMD  = 8;
   localparam int unsigned LEN_DATA = 16;

   typedef struct packed {
      logic       lock;   // bit 7
      logic [2:0] prot;   // bits 4:2
      logic       wel;    // bit 1
      logic       busy;   // bit 0
   } stat_t;

   function automatic logic [7:0] stat_to_byte(stat_t s);
      return {s.lock, 2'b00, s.prot, s.wel, s.busy};
   endfunction
endpackage

// File: rtl/sfl_pin_sync.sv
module sfl_pin_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sfl_frame_rx.sv
module sfl_frame_rx
   import sfl_pkg::*;
#(
   parameter int unsigned CNT_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       mosi,
   output logic       ev_wren,
   output logic       ev_wrsr,
   output logic [7:0] wr_byte,
   output logic       rd_sel,
   output logic       sck_fall
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_CMD = CNT_W'(LEN_CMD);
   localparam logic [CNT_W-1:0] CNT_DAT = CNT_W'(LEN_DATA);
   localparam logic [CNT_W-1:0] CNT_LAST_CMD_BIT = CNT_W'(LEN_CMD - 1);

   logic             cs_q, sck_q;
   logic             cs_fall, cs_rise, sck_rise;
   logic [15:0]      shreg;
   logic [CNT_W-1:0] bitcnt;
   logic [7:0]       next_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         cs_q  <= cs_n;
         sck_q <= sck;
      end
   end

   assign cs_fall   = cs_q & ~cs_n;
   assign cs_rise   = ~cs_q & cs_n;
   assign sck_rise  = ~sck_q & sck & ~cs_n;
   assign sck_fall  = sck_q & ~sck & ~cs_n;
   assign next_byte = {shreg[6:0], mosi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         bitcnt <= '0;
         rd_sel <= 1'b0;
      end else if (cs_fall) begin
         bitcnt <= '0;
         rd_sel <= 1'b0;
      end else if (cs_rise) begin
         rd_sel <= 1'b0;
      end else if (sck_rise) begin
         shreg <= {shreg[14:0], mosi};
         if (bitcnt != CNT_MAX) bitcnt <= bitcnt + 1'b1;
         if (bitcnt == CNT_LAST_CMD_BIT && next_byte == OP_RDSR) rd_sel <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_wren <= 1'b0;
         ev_wrsr <= 1'b0;
         wr_byte <= '0;
      end else begin
         ev_wren <= cs_rise && bitcnt == CNT_CMD && shreg[7:0] == OP_WREN;
         ev_wrsr <= cs_rise && bitcnt == CNT_DAT && shreg[15:8] == OP_WRSR;
         wr_byte <= shreg[7:0];
      end
   end
endmodule

// File: rtl/sfl_stat_core.sv
module sfl_stat_core
   import sfl_pkg::*;
#(
   parameter int unsigned TW_CYCLES = 4096
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_wren,
   input  logic       ev_wrsr,
   input  logic [7:0] wr_byte,
   input  logic       wp_n,
   output logic [7:0] stat_byte
);
   localparam int unsigned TW_W = (TW_CYCLES < 2) ? 1 : $clog2(TW_CYCLES);
   localparam logic [TW_W-1:0] TW_LOAD = TW_W'(TW_CYCLES - 1);

   stat_t           st;
   logic [TW_W-1:0] tmr;
   logic            locked, take_wr;

   assign locked  = st.lock & ~wp_n;
   assign take_wr = ev_wrsr & st.wel & ~st.busy & ~locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= '0;
         tmr <= '0;
      end else if (st.busy) begin
         if (tmr == '0) begin
            st.busy <= 1'b0;
            st.wel  <= 1'b0;
         end else begin
            tmr <= tmr - 1'b1;
         end
      end else if (take_wr) begin
         st.lock <= wr_byte[7];
         st.prot <= wr_byte[4:2];
         st.busy <= 1'b1;
         tmr     <= TW_LOAD;
      end else if (ev_wren) begin
         st.wel <= 1'b1;
      end
   end

   assign stat_byte = stat_to_byte(st);
endmodule

// File: rtl/sfl_rd_shift.sv
module sfl_rd_shift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       rd_sel,
   input  logic       sck_fall,
   input  logic [7:0] stat_byte,
   output logic       miso
);
   logic [2:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miso <= 1'b0;
         idx  <= 3'd7;
      end else if (cs_n) begin
         miso <= 1'b0;
         idx  <= 3'd7;
      end else if (rd_sel && sck_fall) begin
         miso <= stat_byte[idx];
         idx  <= idx - 3'd1;
      end
   end
endmodule

// File: rtl/sfl_status_writer.sv
module sfl_status_writer #(
   parameter int unsigned TW_CYCLES   = 4096,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_cs_n,
   input  logic       spi_sck,
   input  logic       spi_mosi,
   input  logic       wr_prot_n,
   output logic       spi_miso,
   output logic [7:0] status_o
);
   localparam int unsigned NPINS = 4;
   localparam logic [NPINS-1:0] PIN_RST = 4'b1001; // wp_n and cs_n idle high

   generate
      if (TW_CYCLES < 1) begin : g_bad_tw
         $error("TW_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_W < 5) begin : g_bad_cnt
         $error("CNT_W must count past 16 bits");
      end
   endgenerate

   logic [NPINS-1:0] pins_s;
   logic             cs_s, sck_s, mosi_s, wp_s;
   logic             ev_wren, ev_wrsr, rd_sel, sck_fall;
   logic [7:0]       wr_byte;

   sfl_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({wr_prot_n, spi_mosi, spi_sck, spi_cs_n}),
      .q(pins_s)
   );

   assign cs_s   = pins_s[0];
   assign sck_s  = pins_s[1];
   assign mosi_s = pins_s[2];
   assign wp_s   = pins_s[3];

   sfl_frame_rx #(.CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_s), .sck(sck_s), .mosi(mosi_s),
      .ev_wren(ev_wren), .ev_wrsr(ev_wrsr), .wr_byte(wr_byte),
      .rd_sel(rd_sel), .sck_fall(sck_fall)
   );

   sfl_stat_core #(.TW_CYCLES(TW_CYCLES)) u_core (
      .clk(clk), .rst_n(rst_n), .ev_wren(ev_wren), .ev_wrsr(ev_wrsr),
      .wr_byte(wr_byte), .wp_n(wp_s), .stat_byte(status_o)
   );

   sfl_rd_shift u_tx (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_s), .rd_sel(rd_sel),
      .sck_fall(sck_fall), .stat_byte(status_o), .miso(spi_miso)
   );
endmodule

// File: rtl/sfl_status_writer_chk.sv
module sfl_status_writer_chk #(
   parameter int unsigned TW_CYCLES = 4096
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] stat,
   input logic       wp_sync
);
   logic [31:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       busy_len <= '0;
      else if (stat[0]) busy_len <= busy_len + 32'd1;
      else              busy_len <= '0;
   end

   AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[0]) |-> $past(stat[1])) else $error("busy without latch"); // R3

   AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(stat[0]) |-> $stable({stat[7], stat[4:2]})) else $error("fields moved"); // R5

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      stat[6:5] == 2'b00) else $error("reserved bits set"); // R5

   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat[0]) |-> busy_len == 32'(TW_CYCLES)) else $error("busy length"); // R6

   AST_WEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat[0]) |-> !stat[1]) else $error("latch kept"); // R7

   AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[0]) |-> !($past(stat[7]) && !$past(wp_sync))) else $error("locked write"); // R8

   AST_WEL_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[1]) |-> !$past(stat[0])) else $error("latch set while busy"); // R10
endmodule

bind sfl_status_writer sfl_status_writer_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .stat(status_o), .wp_sync(wp_s)
);

// File: tb/sfl_status_writer_bench.sv
module sfl_status_writer_bench;
   localparam int unsigned TW   = 2000;
   localparam int unsigned HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
   logic       miso;
   logic [7:0] stat;
   int         n_chk = 0, n_err = 0;
   int         run = 0, last_run = 0;
   logic [7:0] rd;

   always #2.5 clk = ~clk;

   sfl_status_writer #(.TW_CYCLES(TW)) u_sfl_status_writer (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
      .spi_mosi(mosi), .wr_prot_n(wp_n), .spi_miso(miso), .status_o(stat)
   );

   // {wren, wp_n, nbits[4:0], data[7:0], expected[7:0]}
   localparam logic [22:0] VEC [9] = '{
      {1'b1, 1'b1, 5'd16, 8'h9C, 8'h9C},
      {1'b0, 1'b1, 5'd16, 8'h00, 8'h9C},
      {1'b1, 1'b0, 5'd16, 8'h00, 8'h9E},
      {1'b0, 1'b1, 5'd16, 8'h00, 8'h00},
      {1'b1, 1'b1, 5'd15, 8'hFF, 8'h02},
      {1'b0, 1'b1, 5'd17, 8'hFF, 8'h02},
      {1'b0, 1'b1, 5'd16, 8'h6F, 8'h0C},
      {1'b1, 1'b0, 5'd16, 8'h80, 8'h80},
      {1'b1, 1'b0, 5'd16, 8'h00, 8'h82}
   };

   always @(posedge clk) begin
      if (stat[0]) run <= run + 1;
      else if (run != 0) begin
         last_run <= run;
         run <= 0;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic half_period();
      repeat (HALF) @(negedge clk);
   endtask

   // send the top n bits of pat MSB first; capture serial output on rising edges 9..16
   task automatic frame(input logic [23:0] pat, input int n, output logic [7:0] got);
      got = '0;
      @(negedge clk);
      cs_n = 1'b0;
      half_period();
      for (int i = 0; i < n; i++) begin
         mosi = pat[23-i];
         half_period();
         sck = 1'b1;
         if (i >= 8 && i < 16) got = {got[6:0], miso};
         half_period();
         sck = 1'b0;
      end
      half_period();
      cs_n = 1'b1;
      half_period();
      half_period();
   endtask

   task automatic read_status(output logic [7:0] v);
      frame({8'h05, 16'h0}, 16, v);
   endtask

   task automatic wait_idle();
      repeat (8) @(negedge clk);
      while (stat[0]) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (2000 * 75) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] dummy;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      check("R1 status after reset", 32'(stat), 32'h00);
      check("R1 miso idle", 32'(miso), 32'h0);
      read_status(rd);
      check("R9 read after reset", 32'(rd), 32'h00);

      // vector walk: R2 R3 R4 R5 R8
      foreach (VEC[k]) begin
         wp_n = VEC[k][21];
         repeat (4) @(negedge clk);
         if (VEC[k][22]) frame({8'h06, 16'h0}, 8, dummy);
         frame({8'h01, VEC[k][15:8], 8'h00}, int'(VEC[k][20:16]), dummy);
         wait_idle();
         read_status(rd);
         check($sformatf("R3/R4/R5/R8 row %0d read", k), 32'(rd), 32'(VEC[k][7:0]));
         check($sformatf("R9 row %0d parallel", k), 32'(stat), 32'(VEC[k][7:0]));
      end

      // R6 R9 R10 R7: write, read while busy, ignored write while busy
      wp_n = 1'b1;
      repeat (4) @(negedge clk);
      frame({8'h01, 8'h84, 8'h00}, 16, dummy);
      read_status(rd);
      check("R9 read during busy", 32'(rd), 32'h87);
      frame({8'h01, 8'h00, 8'h00}, 16, dummy);
      check("R10 still busy during ignored write", 32'(stat[0]), 32'h1);
      wait_idle();
      read_status(rd);
      check("R10 R7 after busy", 32'(rd), 32'h84);
      check("R6 busy length", 32'(last_run), 32'(TW));

      // R2 frame length for write-enable
      frame({8'h06, 8'h80, 8'h00}, 9, dummy);
      read_status(rd);
      check("R2 nine-bit enable ignored", 32'(rd), 32'h84);
      frame({8'h06, 16'h0}, 7, dummy);
      read_status(rd);
      check("R2 seven-bit enable ignored", 32'(rd), 32'h84);
      frame({8'h06, 16'h0}, 8, dummy);
      read_status(rd);
      check("R2 eight-bit enable", 32'(rd), 32'h86);

      // R6 R7 second busy pulse from a clean write
      frame({8'h01, 8'h08, 8'h00}, 16, dummy);
      wait_idle();
      check("R6 busy length again", 32'(last_run), 32'(TW));
      check("R7 latch cleared", 32'(stat), 32'h08);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule